// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives two audio clocks from one source clock. The first is a master clock. The second is a serial bit clock. Each comes from a cascade of stages: a prescaler that divides by 1 or by 8, a modulus divider from 1 to 256, and a final halving toggle. The bit clock path also passes through a fine divider from 1 to 16 before its own halving toggle. The master clock is therefore the source divided by 2·P·M. The bit clock is the source divided by 2·P·M·F.

Each output is a divided clock level with a 50% duty cycle and its own polarity control. Each output also has a one-cycle enable pulse, issued the cycle before the output level rises. Three path modes are available:

- Divided mode, the normal case.
- Bypass mode. The source clock is routed straight to the master clock output with no division.
- Pin-input mode. The master clock pin is an input, its output enable is dropped, and the bit clock divider counts rising edges of the pin instead of source cycles.

Each divider stage holds a private copy of its setting. It takes a new value only when its counter wraps. A change made at any time therefore never produces a runt phase.

Top module: `audclk_divchain`

## Requirements
- R1: While reset is held, with cfg_mode = 0 and both polarity bits 0, mck_ce, bck_ce, mck_out and bck_out are all 0 and mck_oe is 1.
- R2: In divided mode (cfg_mode = 0), mck_ce pulses once every 2·P·M source cycles, where P = 8 when cfg_presc8 = 1 and P = 1 otherwise, and M = cfg_mod_m1 + 1. mck_out is high for P·M of those cycles.
- R3: In divided mode, bck_ce pulses once every 2·P·M·F source cycles, where F = cfg_fine_m1 + 1. bck_out is high for P·M·F of those cycles.
- R4: With all divider fields zero the ratio is 2 on both outputs (the minimum). With cfg_mod_m1 = 255 and P = 1, the master clock ratio is 512. With cfg_fine_m1 = 15 and P = M = 1, the bit clock ratio is 32.
- R5: In bypass mode (cfg_mode = 1), mck_ce is 1 in every cycle and mck_out follows the source clock XOR cfg_mck_inv. The bit clock ratio stays 2·P·M·F.
- R6: In pin-input mode (cfg_mode = 2), mck_oe, mck_out and mck_ce are 0. bck_ce pulses once every 2·P·M·F rising edges of mck_pin_in. With no pin edges, bck_ce never pulses.
- R7: cfg_bck_inv inverts bck_out and cfg_mck_inv inverts mck_out. In either polarity, the output is 0 in the cycle where its enable pulse is high and 1 in the next cycle.
- R8: A divider setting changed while running is taken up only at a wrap of its counter. During a modulus change with P = F = 1, every mck_out phase lasts exactly the old M or the new M cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Path mode: 0 divided, 1 bypass, 2 pin input, 3 treated as divided |
| cfg_presc8 | input | 1 | Prescaler divides by 8 when 1, by 1 when 0 |
| cfg_mod_m1 | input | MOD_W | Modulus divider value minus one |
| cfg_fine_m1 | input | FINE_W | Fine divider value minus one (bit clock path only) |
| cfg_bck_inv | input | 1 | Invert bit clock output |
| cfg_mck_inv | input | 1 | Invert master clock output |
| mck_pin_in | input | 1 | Master clock pin value when used as input |
| mck_out | output | 1 | Master clock output level |
| mck_oe | output | 1 | Master clock pin output enable |
| mck_ce | output | 1 | Master clock rising-edge enable pulse |
| bck_out | output | 1 | Bit clock output level |
| bck_ce | output | 1 | Bit clock rising-edge enable pulse |

## Verification
The enable pulses are combinational from the counter registers and are sampled on the falling edge. Each output level is a registered toggle, so it turns 1 one falling-edge sample after its pulse; the polarity checks sample exactly there. Periods and high times are counted as intervals between consecutive pulses, so reset and pin-synchronizer latency do not shift the expected values. A setting only reaches the outputs after the old counters wrap, so after each reconfiguration three bit clock pulses are discarded before anything is measured.

// File: rtl/acd_pkg.sv
package acd_pkg;

  typedef enum logic [1:0] {
    MODE_DIV = 2'd0,
    MODE_BYP = 2'd1,
    MODE_PIN = 2'd2,
    MODE_RSV = 2'd3
  } path_mode_e;

endpackage

// File: rtl/acd_stage_cnt.sv
module acd_stage_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] lim_new,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_q, lim_d;

  always_comb begin
    tick  = en && (cnt_q == lim_q);
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (tick) begin
      cnt_d = '0;
      lim_d = lim_new;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // R8
  lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lim_q));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

endmodule

// File: rtl/acd_half_toggle.sv
module acd_half_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic inv,
  output logic lvl,
  output logic ce
);

  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (tick) q_d = ~q_q;
    ce  = tick && (q_q == inv);
    lvl = q_q ^ inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  // R3
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q_q));

  // R7
  ce_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q_q != $past(q_q)));

endmodule

// File: rtl/acd_pin_sync.sv
module acd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  always_comb rise = sh_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/audclk_divchain.sv
module audclk_divchain
  import acd_pkg::*;
#(
  parameter int MOD_W       = 8,
  parameter int FINE_W      = 4,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_presc8,
  input  logic [MOD_W-1:0]  cfg_mod_m1,
  input  logic [FINE_W-1:0] cfg_fine_m1,
  input  logic              cfg_bck_inv,
  input  logic              cfg_mck_inv,
  input  logic              mck_pin_in,
  output logic              mck_out,
  output logic              mck_oe,
  output logic              mck_ce,
  output logic              bck_out,
  output logic              bck_ce
);

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_DIV - 1);

  logic [1:0] rst_pipe_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  path_mode_e mode;
  logic       is_pin, is_byp;
  logic       pin_rise, src_en;
  logic [PRE_W-1:0] pre_lim;
  logic       pre_tick, mod_tick, fine_tick;
  logic       mq_lvl, mq_ce, bq_lvl, bq_ce;

  always_comb begin
    mode    = path_mode_e'(cfg_mode);
    is_pin  = (mode == MODE_PIN);
    is_byp  = (mode == MODE_BYP);
    src_en  = rst_s & (is_pin ? pin_rise : 1'b1);
    pre_lim = cfg_presc8 ? PRE_LIM : '0;
  end

  acd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_s), .pin (mck_pin_in), .rise (pin_rise)
  );

  acd_stage_cnt #(.W(PRE_W)) u_pre (
    .clk (clk), .rst_n (rst_s), .en (src_en), .lim_new (pre_lim), .tick (pre_tick)
  );

  acd_stage_cnt #(.W(MOD_W)) u_mod (
    .clk (clk), .rst_n (rst_s), .en (pre_tick), .lim_new (cfg_mod_m1), .tick (mod_tick)
  );

  acd_stage_cnt #(.W(FINE_W)) u_fine (
    .clk (clk), .rst_n (rst_s), .en (mod_tick), .lim_new (cfg_fine_m1), .tick (fine_tick)
  );

  acd_half_toggle u_mck_half (
    .clk (clk), .rst_n (rst_s), .tick (mod_tick), .inv (cfg_mck_inv),
    .lvl (mq_lvl), .ce (mq_ce)
  );

  acd_half_toggle u_bck_half (
    .clk (clk), .rst_n (rst_s), .tick (fine_tick), .inv (cfg_bck_inv),
    .lvl (bq_lvl), .ce (bq_ce)
  );

  always_comb begin
    mck_oe  = ~is_pin;
    bck_out = bq_lvl;
    bck_ce  = bq_ce;
    if (is_pin) begin
      mck_out = 1'b0;
      mck_ce  = 1'b0;
    end else if (is_byp) begin
      mck_out = clk ^ cfg_mck_inv;
      mck_ce  = rst_s;
    end else begin
      mck_out = mq_lvl;
      mck_ce  = mq_ce;
    end
  end

  // R6
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (is_pin && !pin_rise) |-> !pre_tick);

endmodule

// File: tb/sim_audclk_divchain.sv
module sim_audclk_divchain;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic       cfg_presc8;
  logic [7:0] cfg_mod_m1;
  logic [3:0] cfg_fine_m1;
  logic       cfg_bck_inv, cfg_mck_inv;
  logic       mck_pin_in = 1'b0;
  logic       pin_on = 1'b0;
  logic       mck_out, mck_oe, mck_ce, bck_out, bck_ce;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  initial begin
    #3;
    forever begin
      #30;
      if (pin_on) mck_pin_in = ~mck_pin_in;
    end
  end

  audclk_divchain u0 (
    .clk (clk), .rst_n (rst_n), .cfg_mode (cfg_mode), .cfg_presc8 (cfg_presc8),
    .cfg_mod_m1 (cfg_mod_m1), .cfg_fine_m1 (cfg_fine_m1),
    .cfg_bck_inv (cfg_bck_inv), .cfg_mck_inv (cfg_mck_inv),
    .mck_pin_in (mck_pin_in), .mck_out (mck_out), .mck_oe (mck_oe),
    .mck_ce (mck_ce), .bck_out (bck_out), .bck_ce (bck_ce)
  );

  function automatic int exp_mck(input bit p8, input int m1);
    return 2 * (p8 ? 8 : 1) * (m1 + 1);
  endfunction

  function automatic int exp_bck(input bit p8, input int m1, input int f1);
    return exp_mck(p8, m1) * (f1 + 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(1900000);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  function automatic bit ce_of(input bit use_bck);
    return use_bck ? bck_ce : mck_ce;
  endfunction

  function automatic bit lvl_of(input bit use_bck);
    return use_bck ? bck_out : mck_out;
  endfunction

  task automatic wait_ce(input bit use_bck, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (ce_of(use_bck)) begin ok = 1'b1; break; end
    end
  endtask

  // Period and high time between two consecutive enable pulses.
  task automatic measure(input bit use_bck, output int per, output int hi);
    bit ok;
    per = -1; hi = -1;
    wait_ce(use_bck, ok);
    if (ok) begin
      per = 0; hi = 0;
      for (int i = 0; i < 40000; i++) begin
        @(negedge clk);
        per++;
        if (lvl_of(use_bck)) hi++;
        if (ce_of(use_bck)) break;
      end
    end
  endtask

  task automatic settle();
    bit ok;
    for (int i = 0; i < 3; i++) wait_ce(1'b1, ok);
  endtask

  task automatic setcfg(input bit [1:0] md, input bit p8, input int m1, input int f1,
                        input bit bi, input bit mi);
    @(negedge clk);
    cfg_mode = md; cfg_presc8 = p8; cfg_mod_m1 = 8'(m1); cfg_fine_m1 = 4'(f1);
    cfg_bck_inv = bi; cfg_mck_inv = mi;
  endtask

  task automatic run_div(input string req, input bit p8, input int m1, input int f1,
                         input bit bi, input bit mi);
    int per, hi;
    setcfg(2'd0, p8, m1, f1, bi, mi);
    settle();
    measure(1'b1, per, hi);
    chk(req, "bck period", per, exp_bck(p8, m1, f1));
    chk(req, "bck high", hi, exp_bck(p8, m1, f1) / 2);
    measure(1'b0, per, hi);
    chk(req, "mck period", per, exp_mck(p8, m1));
    chk(req, "mck high", hi, exp_mck(p8, m1) / 2);
  endtask

  initial begin
    int per, hi, seen, bad, runlen, short_runs;
    bit prev, first, ok;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg_mode = 2'd0; cfg_presc8 = 1'b0; cfg_mod_m1 = '0; cfg_fine_m1 = '0;
    cfg_bck_inv = 1'b0; cfg_mck_inv = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "mck_ce", int'(mck_ce), 0);
    chk("R1", "bck_ce", int'(bck_ce), 0);
    chk("R1", "mck_out", int'(mck_out), 0);
    chk("R1", "bck_out", int'(bck_out), 0);
    chk("R1", "mck_oe", int'(mck_oe), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 minimum ratio
    run_div("R4", 1'b0, 0, 0, 1'b0, 1'b0);
    // R4 largest modulus
    run_div("R4", 1'b0, 255, 0, 1'b0, 1'b0);
    // R4 largest fine value
    run_div("R4", 1'b0, 0, 15, 1'b0, 1'b0);

    // R2 R3 random settings, random polarity
    for (int k = 0; k < 12; k++) begin
      bit p8, bi, mi;
      int m1, f1;
      p8 = 1'($urandom % 2);
      m1 = int'($urandom % 12);
      f1 = int'($urandom % 4);
      bi = 1'($urandom % 2);
      mi = 1'($urandom % 2);
      run_div((k % 2) ? "R2" : "R3", p8, m1, f1, bi, mi);
    end

    // R7 polarity and edge alignment
    for (int pol = 0; pol < 2; pol++) begin
      setcfg(2'd0, 1'b0, 2, 1, 1'(pol), 1'(pol));
      settle();
      wait_ce(1'b1, ok);
      chk("R7", "bck_out at ce", int'(bck_out), 0);
      @(negedge clk);
      chk("R7", "bck_out after ce", int'(bck_out), 1);
      wait_ce(1'b0, ok);
      chk("R7", "mck_out at ce", int'(mck_out), 0);
      @(negedge clk);
      chk("R7", "mck_out after ce", int'(mck_out), 1);
    end
    setcfg(2'd0, 1'b0, 2, 1, 1'b0, 1'b0);
    settle();
    wait_ce(1'b1, ok);
    @(negedge clk);
    chk("R7", "bck_out non-inverted phase", int'(bck_out), 1);
    setcfg(2'd0, 1'b0, 2, 1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7", "bck_out inverted phase", int'(bck_out), 0);

    // R5 bypass
    setcfg(2'd1, 1'b0, 2, 0, 1'b0, 1'b1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!mck_ce) bad++;
      if (mck_out != 1'b1) bad++;
      @(posedge clk); #2;
      if (mck_out != 1'b0) bad++;
    end
    chk("R5", "bypass ce/level mismatches", bad, 0);
    settle();
    measure(1'b1, per, hi);
    chk("R5", "bck period in bypass", per, exp_bck(1'b0, 2, 0));

    // R6 pin input
    pin_on = 1'b1;
    setcfg(2'd2, 1'b0, 1, 1, 1'b0, 1'b0);
    settle();
    measure(1'b1, per, hi);
    chk("R6", "bck period in pin periods x6", per, exp_bck(1'b0, 1, 1) * 6);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mck_oe || mck_out || mck_ce) bad++;
    end
    chk("R6", "mck pin outputs active", bad, 0);
    pin_on = 1'b0;
    repeat (10) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bck_ce) seen++;
    end
    chk("R6", "bck pulses without pin edges", seen, 0);

    // R8 modulus change applied at wrap: phases of 5 or 2 only
    setcfg(2'd0, 1'b0, 4, 0, 1'b0, 1'b0);
    settle();
    repeat (int'($urandom % 7) + 1) @(negedge clk);
    cfg_mod_m1 = 8'd1;
    first = 1'b1; bad = 0; short_runs = 0; runlen = 0;
    prev = mck_out;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (mck_out == prev) runlen++;
      else begin
        if (!first) begin
          if (runlen + 1 != 5 && runlen + 1 != 2) bad++;
          if (runlen + 1 == 2) short_runs++;
        end
        first = 1'b0;
        runlen = 0;
        prev = mck_out;
      end
    end
    chk("R8", "runt or stretched phases", bad, 0);
    chk("R8", "new modulus reached", int'(short_runs > 4), 1);

    finish_run();
  end

endmodule